// File: doc/BRIEF.md
# Atomic read-modify-write memory unit

This block performs one atomic memory operation at a time on a simple synchronous memory port. A request carries an opcode, an access size of 1, 2, 4 or 8 bytes, an address, a register operand and two ordering bits. The unit checks that the address is naturally aligned. It then locks the memory port, announces the write address, reads the old value and computes the new value at the access width. It writes that value back and reports completion with a one-cycle done pulse. On success the pulse carries the old memory value, sign-extended to the register width.

The memory answers each command in the cycle after it is issued. It reports a fault flag for every command and a write-accepted flag for writes. A fault at any step ends the operation early with no register update and reports the faulting address. A write that the memory refuses is reported as an internal error kind. The two ordering bits are not interpreted: they are only carried on every memory command.

Top module: `amo_rmw_unit`

## Requirements
- R1: `req_ready` is high exactly when no operation is in progress, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Out of reset the unit is idle with `done_o` low.
- R2: Size codes are 0=1, 1=2, 2=4 and 3=8 bytes. An address whose low log2(bytes) bits are not all zero causes `done_o` in the cycle after acceptance, with `done_kind_o`=1, `done_addr_o` equal to the request address and no memory command at all.
- R3: After an aligned request is accepted, the unit issues three commands on consecutive cycles, one per cycle: `mem_ea`, then `mem_rd`, then `mem_wr`. A completion cycle follows with no command. `mem_lock` is high and `mem_addr`/`mem_size` hold steady over all four cycles.
- R4: Opcodes 0=swap, 1=add, 2=xor, 3=and and 4=or operate on the operand truncated to the access width and the old value. `mem_wdata` carries the result in its low bytes and zeros above; codes 9 to 15 act as swap.
- R5: Opcodes 5 (min) and 6 (max) compare the width-sized values as two's-complement numbers.
- R6: Opcodes 7 (minu) and 8 (maxu) compare the width-sized values as unsigned numbers.
- R7: On success `done_o` rises four cycles after the accepting edge, for one cycle only. At that point `done_kind_o`=0, `done_wen_o`=1 and `done_result_o` holds the old value sign-extended from the access width, whatever the opcode.
- R8: A fault reported for any command stops the sequence. No later command is issued, so memory is left unchanged when the read faults. `done_o` follows in the next cycle with `done_kind_o`=2, the request address, `done_wen_o`=0 and a zero result.
- R9: A write that the memory does not accept ends with `done_kind_o`=3, `done_wen_o`=0 and a zero result, at the normal completion time.
- R10: `mem_aq` and `mem_rl` equal the request's ordering bits on every command of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_op | input | 4 | Operation code |
| req_size | input | 2 | Access size code (3 is reported as kind 4 when XLEN is 32) |
| req_addr | input | ADDR_W | Byte address |
| req_operand | input | XLEN | Register operand |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| mem_lock | output | 1 | Memory port held for this unit |
| mem_ea | output | 1 | Write-address announcement command |
| mem_rd | output | 1 | Read command |
| mem_wr | output | 1 | Write command |
| mem_addr | output | ADDR_W | Command address |
| mem_size | output | 2 | Command size code |
| mem_wdata | output | XLEN | Write data, right-aligned |
| mem_aq | output | 1 | Acquire bit carried on commands |
| mem_rl | output | 1 | Release bit carried on commands |
| mem_rsp_fault | input | 1 | Fault for the previous cycle's command |
| mem_rsp_rdata | input | XLEN | Read data for the previous cycle's read |
| mem_rsp_wr_ok | input | 1 | Previous cycle's write was accepted |
| done_o | output | 1 | Operation complete pulse |
| done_wen_o | output | 1 | Destination register must be written |
| done_fault_o | output | 1 | Operation ended in a fault |
| done_kind_o | output | 3 | 0 ok, 1 misaligned, 2 access fault, 3 write refused, 4 bad size |
| done_addr_o | output | ADDR_W | Faulting address |
| done_result_o | output | XLEN | Sign-extended old value |

## Verification
A sequencer stuck in the wrong state shows at once on the command lines. A command appears out of order, fails to appear, or appears while `mem_lock` is low, and the cycle-by-cycle comparison catches that in the same cycle. A wrong width or sign decision in the datapath shows in `mem_wdata` during the write cycle, two cycles before done. A wrong captured old value shows only at the done pulse. Fault handling errors show up in two places: a command issued after a faulted response, visible in the next cycle, and a wrong kind or non-zero result on the done pulse.

// File: rtl/amo_pkg.sv
package amo_pkg;
   typedef enum logic [3:0] {
      OP_SWAP = 4'd0, OP_ADD = 4'd1, OP_XOR = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
      OP_MIN = 4'd5, OP_MAX = 4'd6, OP_MINU = 4'd7, OP_MAXU = 4'd8
   } amo_op_e;

   typedef enum logic [2:0] {
      FK_NONE = 3'd0, FK_MISALIGN = 3'd1, FK_ACCESS = 3'd2,
      FK_REFUSED = 3'd3, FK_BADSIZE = 3'd4
   } fault_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_EA, ST_RD, ST_WR, ST_FIN
   } seq_state_e;
endpackage

// File: rtl/amo_width_ext.sv
module amo_width_ext #(
   parameter int XLEN = 64
) (
   input  logic [1:0]      size,
   input  logic            sgn,
   input  logic [XLEN-1:0] din,
   output logic [XLEN-1:0] dout
);
   localparam int NSZ = (XLEN == 64) ? 4 : 3;

   logic [XLEN-1:0] lane [NSZ];

   for (genvar g = 0; g < NSZ; g++) begin : g_lane
      localparam int W = 8 << g;
      if (W == XLEN) begin : g_full
         assign lane[g] = din;
      end else begin : g_part
         assign lane[g] = {{(XLEN-W){sgn & din[W-1]}}, din[W-1:0]};
      end
   end

   always_comb begin
      dout = din;
      for (int i = 0; i < NSZ; i++)
         if (int'(size) == i) dout = lane[i];
   end
endmodule

// File: rtl/amo_align_chk.sv
module amo_align_chk #(
   parameter int XLEN = 64
) (
   input  logic [2:0] addr_lo,
   input  logic [1:0] size,
   output logic       misalign,
   output logic       badsize
);
   always_comb begin
      badsize = (XLEN != 64) && (size == 2'd3);
      unique case (size)
         2'd0:    misalign = 1'b0;
         2'd1:    misalign = addr_lo[0];
         2'd2:    misalign = |addr_lo[1:0];
         default: misalign = |addr_lo;
      endcase
   end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [3:0]      op,
   input  logic [1:0]      size,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] opnd,
   output logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] ret_val
);
   logic [XLEN-1:0] a_s, a_u, b_s, b_u, res;

   amo_width_ext #(.XLEN(XLEN)) u_old_s (.size(size), .sgn(1'b1), .din(old_val), .dout(a_s));
   amo_width_ext #(.XLEN(XLEN)) u_old_u (.size(size), .sgn(1'b0), .din(old_val), .dout(a_u));
   amo_width_ext #(.XLEN(XLEN)) u_opn_s (.size(size), .sgn(1'b1), .din(opnd),    .dout(b_s));
   amo_width_ext #(.XLEN(XLEN)) u_opn_u (.size(size), .sgn(1'b0), .din(opnd),    .dout(b_u));
   amo_width_ext #(.XLEN(XLEN)) u_mask  (.size(size), .sgn(1'b0), .din(res),     .dout(wdata));

   assign ret_val = a_s;

   always_comb begin
      unique case (op)
         OP_ADD:  res = a_u + b_u;
         OP_XOR:  res = a_u ^ b_u;
         OP_AND:  res = a_u & b_u;
         OP_OR:   res = a_u | b_u;
         OP_MIN:  res = ($signed(b_s) < $signed(a_s)) ? b_u : a_u;
         OP_MAX:  res = ($signed(b_s) > $signed(a_s)) ? b_u : a_u;
         OP_MINU: res = (b_u < a_u) ? b_u : a_u;
         OP_MAXU: res = (b_u > a_u) ? b_u : a_u;
         default: res = b_u;
      endcase
   end
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
   import amo_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_op,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [XLEN-1:0]   req_operand,
   input  logic              req_aq,
   input  logic              req_rl,
   output logic              mem_lock,
   output logic              mem_ea,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [XLEN-1:0]   mem_wdata,
   output logic              mem_aq,
   output logic              mem_rl,
   input  logic              mem_rsp_fault,
   input  logic [XLEN-1:0]   mem_rsp_rdata,
   input  logic              mem_rsp_wr_ok,
   output logic              done_o,
   output logic              done_wen_o,
   output logic              done_fault_o,
   output logic [2:0]        done_kind_o,
   output logic [ADDR_W-1:0] done_addr_o,
   output logic [XLEN-1:0]   done_result_o
);
   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("amo_rmw_unit: XLEN must be 32 or 64");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("amo_rmw_unit: ADDR_W must be at least 3");
   end

   seq_state_e        st;
   logic [3:0]        op_q;
   logic [1:0]        size_q;
   logic [ADDR_W-1:0] addr_q;
   logic [XLEN-1:0]   opnd_q, ret_q;
   logic              aq_q, rl_q;
   logic              misalign, badsize;
   logic [XLEN-1:0]   alu_wdata, alu_ret;
   fault_kind_e       kind_q;

   amo_align_chk #(.XLEN(XLEN)) u_align (
      .addr_lo(req_addr[2:0]), .size(req_size), .misalign(misalign), .badsize(badsize)
   );

   amo_alu #(.XLEN(XLEN)) u_alu (
      .op(op_q), .size(size_q), .old_val(mem_rsp_rdata), .opnd(opnd_q),
      .wdata(alu_wdata), .ret_val(alu_ret)
   );

   assign req_ready = (st == ST_IDLE);
   assign mem_lock  = (st != ST_IDLE);
   assign mem_ea    = (st == ST_EA);
   assign mem_rd    = (st == ST_RD) && !mem_rsp_fault;
   assign mem_wr    = (st == ST_WR) && !mem_rsp_fault;
   assign mem_addr  = addr_q;
   assign mem_size  = size_q;
   assign mem_wdata = alu_wdata;
   assign mem_aq    = aq_q;
   assign mem_rl    = rl_q;

   assign done_kind_o  = kind_q;
   assign done_fault_o = (kind_q != FK_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= ST_IDLE;
         op_q          <= '0;
         size_q        <= '0;
         addr_q        <= '0;
         opnd_q        <= '0;
         ret_q         <= '0;
         aq_q          <= 1'b0;
         rl_q          <= 1'b0;
         done_o        <= 1'b0;
         done_wen_o    <= 1'b0;
         kind_q        <= FK_NONE;
         done_addr_o   <= '0;
         done_result_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               op_q   <= req_op;
               size_q <= req_size;
               addr_q <= req_addr;
               opnd_q <= req_operand;
               aq_q   <= req_aq;
               rl_q   <= req_rl;
               if (misalign || badsize) begin
                  done_o        <= 1'b1;
                  done_wen_o    <= 1'b0;
                  kind_q        <= badsize ? FK_BADSIZE : FK_MISALIGN;
                  done_addr_o   <= req_addr;
                  done_result_o <= '0;
               end else begin
                  st <= ST_EA;
               end
            end
            ST_EA: st <= ST_RD;
            ST_RD, ST_WR: begin
               if (mem_rsp_fault) begin
                  st            <= ST_IDLE;
                  done_o        <= 1'b1;
                  done_wen_o    <= 1'b0;
                  kind_q        <= FK_ACCESS;
                  done_addr_o   <= addr_q;
                  done_result_o <= '0;
               end else begin
                  st <= (st == ST_RD) ? ST_WR : ST_FIN;
                  if (st == ST_WR) ret_q <= alu_ret;
               end
            end
            default: begin
               st     <= ST_IDLE;
               done_o <= 1'b1;
               if (mem_rsp_fault || !mem_rsp_wr_ok) begin
                  done_wen_o    <= 1'b0;
                  kind_q        <= mem_rsp_fault ? FK_ACCESS : FK_REFUSED;
                  done_addr_o   <= addr_q;
                  done_result_o <= '0;
               end else begin
                  done_wen_o    <= 1'b1;
                  kind_q        <= FK_NONE;
                  done_addr_o   <= '0;
                  done_result_o <= ret_q;
               end
            end
         endcase
      end
   end

   p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_lock);
   p_misalign_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && misalign) |=> (done_o && done_kind_o == 3'd1 && !mem_lock && !mem_ea));
   p_ea_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !misalign && !badsize) |=> mem_ea);
   p_rd_after_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> $past(mem_ea));
   p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));
   p_one_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_ea, mem_rd, mem_wr}));
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && $past(mem_lock)) |-> ($stable(mem_addr) && $stable(mem_size)));
   p_fault_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && done_fault_o) |-> (done_result_o == '0 && !done_wen_o));
   p_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN && !mem_rsp_fault && !mem_rsp_wr_ok) |=> (done_o && done_kind_o == 3'd3));
endmodule

// File: tb/amo_rmw_unit_tb.sv
module amo_rmw_unit_tb;
   localparam int XLEN = 64;
   localparam int AW   = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [3:0] req_op = '0;
   logic [1:0] req_size = '0;
   logic [AW-1:0] req_addr = '0;
   logic [XLEN-1:0] req_operand = '0;
   logic req_aq = 1'b0, req_rl = 1'b0;
   logic mem_lock, mem_ea, mem_rd, mem_wr, mem_aq, mem_rl;
   logic [AW-1:0] mem_addr;
   logic [1:0] mem_size;
   logic [XLEN-1:0] mem_wdata;
   logic mem_rsp_fault = 1'b0, mem_rsp_wr_ok = 1'b1;
   logic [XLEN-1:0] mem_rsp_rdata = '0;
   logic done_o, done_wen_o, done_fault_o;
   logic [2:0] done_kind_o;
   logic [AW-1:0] done_addr_o;
   logic [XLEN-1:0] done_result_o;

   int total = 0, bad = 0, cyc = 0;
   int inj = 0;   // 0 none, 1 ea fault, 2 read fault, 3 write fault, 4 write refused
   logic [7:0] mem [256];

   always #2.5 clk = ~clk;

   amo_rmw_unit #(.XLEN(XLEN), .ADDR_W(AW)) u_dut (
      .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_size, .req_addr, .req_operand,
      .req_aq, .req_rl, .mem_lock, .mem_ea, .mem_rd, .mem_wr, .mem_addr, .mem_size,
      .mem_wdata, .mem_aq, .mem_rl, .mem_rsp_fault, .mem_rsp_rdata, .mem_rsp_wr_ok,
      .done_o, .done_wen_o, .done_fault_o, .done_kind_o, .done_addr_o, .done_result_o
   );

   // behavioural memory: answers every command one cycle later
   always @(posedge clk) begin
      mem_rsp_fault <= (mem_ea && inj == 1) || (mem_rd && inj == 2) || (mem_wr && inj == 3);
      mem_rsp_wr_ok <= !(mem_wr && inj == 4);
      if (mem_rd)
         for (int i = 0; i < 8; i++) mem_rsp_rdata[8*i +: 8] <= mem[(mem_addr[7:0] + i) & 255];
      if (mem_wr && inj != 3 && inj != 4)
         for (int i = 0; i < (1 << mem_size); i++) mem[(mem_addr[7:0] + i) & 255] <= mem_wdata[8*i +: 8];
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mask_w(input int nb);
      return (nb == 8) ? '1 : ((64'd1 << (8*nb)) - 1);
   endfunction

   function automatic logic [63:0] sext_w(input logic [63:0] v, input int nb);
      int sh = 64 - 8*nb;
      return 64'($signed(v << sh) >>> sh);
   endfunction

   task automatic check_cmds(input bit ea, input bit rd, input bit wr, input bit lock, input string tag);
      chk(mem_ea == ea && mem_rd == rd && mem_wr == wr && mem_lock == lock, tag,
          {60'd0, mem_ea, mem_rd, mem_wr, mem_lock}, {60'd0, ea, rd, wr, lock});
   endtask

   task automatic run_op(input int op, input int sz, input int addr, input logic [63:0] opnd,
                         input bit aq, input bit rl, input int fault_mode);
      int nb = 1 << sz;
      logic [63:0] old_v = '0, a, b, res, exp_w;
      logic [7:0] snap [8];
      bit mis = (addr % nb) != 0;
      for (int i = 0; i < nb; i++) old_v[8*i +: 8] = mem[(addr + i) & 255];
      for (int i = 0; i < 8; i++) snap[i] = mem[(addr + i) & 255];
      a = old_v; b = opnd & mask_w(nb);
      case (op)
         1: res = a + b;
         2: res = a ^ b;
         3: res = a & b;
         4: res = a | b;
         5: res = ($signed(sext_w(b, nb)) < $signed(sext_w(a, nb))) ? b : a;
         6: res = ($signed(sext_w(b, nb)) > $signed(sext_w(a, nb))) ? b : a;
         7: res = (b < a) ? b : a;
         8: res = (b > a) ? b : a;
         default: res = b;
      endcase
      exp_w = res & mask_w(nb);
      inj = fault_mode;

      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready when idle", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_op = 4'(op); req_size = 2'(sz); req_addr = AW'(addr);
      req_operand = opnd; req_aq = aq; req_rl = rl;
      @(negedge clk);
      req_valid = 1'b0;
      if (mis) begin
         chk(done_o && done_kind_o == 3'd1 && done_addr_o == AW'(addr) && !done_wen_o,
             "R2 misaligned done", {done_o, done_kind_o, done_addr_o}, {1'b1, 3'd1, AW'(addr)});
         check_cmds(0, 0, 0, 0, "R2 no memory command");
         @(negedge clk);
         chk(done_o == 1'b0, "R2 done pulse single", {63'd0, done_o}, 64'd0);
         inj = 0;
         return;
      end
      // EA cycle
      check_cmds(1, 0, 0, 1, "R3 ea cycle");
      chk(req_ready == 1'b0, "R1 busy not ready", {63'd0, req_ready}, 64'd0);
      chk(mem_addr == AW'(addr) && mem_size == 2'(sz), "R3 address held", {mem_size, mem_addr}, {2'(sz), AW'(addr)});
      chk(mem_aq == aq && mem_rl == rl, "R10 ordering on ea", {mem_aq, mem_rl}, {aq, rl});
      @(negedge clk);
      // RD cycle
      check_cmds(0, fault_mode != 1, 0, 1, "R3 rd cycle");
      if (fault_mode == 1) begin
         @(negedge clk);
         chk(done_o && done_kind_o == 3'd2 && done_addr_o == AW'(addr) && !done_wen_o && done_result_o == 0,
             "R8 ea fault", {done_o, done_kind_o, done_addr_o}, {1'b1, 3'd2, AW'(addr)});
         check_cmds(0, 0, 0, 0, "R8 no command after ea fault");
         inj = 0;
         return;
      end
      chk(mem_aq == aq && mem_rl == rl, "R10 ordering on rd", {mem_aq, mem_rl}, {aq, rl});
      @(negedge clk);
      // WR cycle
      check_cmds(0, 0, fault_mode != 2, 1, "R3 wr cycle");
      if (fault_mode == 2) begin
         @(negedge clk);
         chk(done_o && done_kind_o == 3'd2 && done_addr_o == AW'(addr) && !done_wen_o && done_result_o == 0,
             "R8 read fault", {done_o, done_kind_o, done_addr_o}, {1'b1, 3'd2, AW'(addr)});
         for (int i = 0; i < 8; i++)
            chk(mem[(addr + i) & 255] == snap[i], "R8 memory untouched", 64'(mem[(addr + i) & 255]), 64'(snap[i]));
         inj = 0;
         return;
      end
      chk(mem_wdata == exp_w, (op >= 7) ? "R6 unsigned write data" : (op >= 5) ? "R5 signed write data" : "R4 write data",
          mem_wdata, exp_w);
      chk(mem_aq == aq && mem_rl == rl && mem_addr == AW'(addr), "R10 ordering on wr", {mem_aq, mem_rl}, {aq, rl});
      @(negedge clk);
      // completion cycle
      check_cmds(0, 0, 0, 1, "R3 final cycle");
      chk(done_o == 1'b0, "R7 not done early", {63'd0, done_o}, 64'd0);
      @(negedge clk);
      if (fault_mode == 3)
         chk(done_o && done_kind_o == 3'd2 && !done_wen_o && done_result_o == 0 && done_addr_o == AW'(addr),
             "R8 write fault", {done_o, done_kind_o, done_result_o[59:0]}, {1'b1, 3'd2, 60'd0});
      else if (fault_mode == 4)
         chk(done_o && done_kind_o == 3'd3 && !done_wen_o && done_result_o == 0,
             "R9 write refused", {done_o, done_kind_o, done_result_o[59:0]}, {1'b1, 3'd3, 60'd0});
      else begin
         chk(done_o && done_kind_o == 3'd0 && done_wen_o && !done_fault_o, "R7 done ok",
             {done_o, done_kind_o, done_wen_o, done_fault_o}, {1'b1, 3'd0, 1'b1, 1'b0});
         chk(done_result_o == sext_w(old_v, nb), "R7 sign-extended old value", done_result_o, sext_w(old_v, nb));
         chk(req_ready == 1'b1, "R1 ready after done", {63'd0, req_ready}, 64'd1);
      end
      inj = 0;
      @(negedge clk);
      chk(done_o == 1'b0, "R7 done single pulse", {63'd0, done_o}, 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      repeat (3) @(negedge clk);
      chk(req_ready && !mem_lock && !done_o, "R1 reset state", {61'd0, req_ready, mem_lock, done_o}, 64'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mem_lock && !done_o && !mem_ea, "R1 idle after reset", {61'd0, req_ready, mem_lock, done_o}, 64'b100);

      // every opcode at every width, including unused code 12 as swap
      for (int op = 0; op < 10; op++) begin
         for (int sz = 0; sz < 4; sz++) begin
            int opc = (op == 9) ? 12 : op;
            int addr = ((op * 4 + sz) * 8 + ((sz < 3) ? (1 << sz) : 0)) & 255;
            logic [63:0] v = {64'h8000_7F81_0123_F0FE} ^ (64'h9E37_79B9_7F4A_7C15 * (op + 3 * sz + 1));
            run_op(opc, sz, addr, v, op[0], sz[0], 0);
         end
      end
      // explicit signed versus unsigned comparisons on a byte: 0x80 vs 0x7F
      mem[200] = 8'h80;
      run_op(5, 0, 200, 64'hFFFF_FFFF_FFFF_FF7F, 0, 0, 0);   // R5 min keeps 0x80
      mem[201] = 8'h80;
      run_op(7, 0, 201, 64'h0000_0000_0000_007F, 0, 0, 0);   // R6 minu picks 0x7F
      mem[202] = 8'h80;
      run_op(6, 0, 202, 64'h7F, 1, 1, 0);                    // R5 max picks 0x7F
      mem[203] = 8'h80;
      run_op(8, 0, 203, 64'h7F, 1, 0, 0);                    // R6 maxu keeps 0x80
      // misaligned cases
      run_op(1, 1, 33, 64'h1, 0, 0, 0);
      run_op(1, 2, 34, 64'h1, 1, 0, 0);
      run_op(1, 3, 44, 64'h1, 0, 1, 0);
      // faults at each step and refused write
      run_op(1, 2, 64, 64'h5, 0, 0, 1);
      run_op(1, 3, 72, 64'h5, 1, 1, 2);
      run_op(2, 1, 80, 64'h5, 0, 1, 3);
      run_op(0, 3, 88, 64'h5, 1, 0, 4);
      // unit still works after faults
      run_op(1, 2, 96, 64'hFFFF_FFFF, 0, 0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule